// File: doc/BRIEF.md
# Core-Side Write-Posting Buffer with Serializing Drain

This block sits between one core's store port and a shared memory bus. A store from the core is captured in a small ring of pending entries and counts as done for the core in the cycle it is accepted. The core never waits for the bus. The ring then writes its entries to shared memory through a single request/grant port, oldest first, one entry per grant. An external arbiter drives the grant, and a grant means the bus is free.

Loads from the owning core look into the ring before memory. If one or more pending entries hold the load's word address, the youngest of them supplies the data. If none match, the data returned by memory is passed through. Other agents read memory directly, so they see a posted store only after its entry has been written out.

A set of serializing events makes the ring empty itself before the core goes on. These are a trap or interrupt, a serializing instruction, an I/O access, a locked access (including an atomic exchange), a bus-init, a load fence and a full fence. The core holds an event line high until the block acknowledges it. While the line is high and entries remain, a busy output holds the core and new stores are refused.

Top module: `sbuf_top`

## Requirements
- R1: A store is accepted in any cycle where `st_valid` and `st_ready` are both high. `st_ready` is high whenever fewer than DEPTH entries are pending and no serializing event is raised. Acceptance never depends on `mem_gnt`.
- R2: When pending entries match `ld_addr` over the full 32 bits, `ld_fwd` is 1 and `ld_data` equals the data of the most recently accepted matching entry. The match covers entries accepted up to the previous clock edge.
- R3: When no pending entry matches `ld_addr`, `ld_fwd` is 0 and `ld_data` equals `mem_rdata`.
- R4: Shared memory at an address with a pending store keeps its previous value until that entry is granted. Agents reading memory therefore never see the posted value early.
- R5: `mem_req` is high exactly when at least one entry is pending, and `mem_addr`/`mem_wdata` carry the oldest entry. While `mem_req` is high and `mem_gnt` is low, all three hold steady. Each cycle with both high retires exactly one entry, so entries reach memory in acceptance order.
- R6: With DEPTH entries pending, `st_ready` is 0 until a grant frees an entry.
- R7: While any bit of `sync_evt` is 1 and entries are pending, `drain_busy` is 1 and `st_ready` is 0. The same holds for each of the seven bits: bit0 trap/interrupt, bit1 serializing instruction, bit2 I/O access, bit3 locked access or atomic exchange, bit4 bus-init, bit5 load fence, bit6 full fence.
- R8: `drain_ack` is 1 exactly when some `sync_evt` bit is 1 and no entry is pending. `drain_busy` is 0 in that cycle.
- R9: After reset, no entry is pending. `mem_req`, `drain_busy` and `ld_fwd` are 0, and `st_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Core offers a store |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store accepted this cycle if offered |
| ld_addr | input | 32 | Owning-core load address |
| ld_data | output | 32 | Load result (forwarded or from memory) |
| ld_fwd | output | 1 | Load result came from a pending entry |
| mem_rdata | input | 32 | Memory read data for `ld_addr` |
| mem_req | output | 1 | Write request to shared bus |
| mem_addr | output | 32 | Write address of oldest entry |
| mem_wdata | output | 32 | Write data of oldest entry |
| mem_gnt | input | 1 | Bus grant; write completes in this cycle |
| sync_evt | input | 7 | Serializing event lines, held until acknowledged |
| drain_busy | output | 1 | Core held while a drain is in progress |
| drain_ack | output | 1 | Buffer empty, raised event may complete |

## Verification
The bench builds the block with DEPTH set to 4 and confines addresses to sixteen words. This makes repeated hits on one address, full-ring stalls and wrap-around of the ring pointers frequent. It also lets every word be checked for forwarding and memory contents after each step. A directed pass fills the ring past capacity with no grants, then drains it slowly. Each of the seven event lines is then raised in turn over a non-empty ring, and a long pseudo-random phase mixes stores, grants, loads and events against a queue model.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned SB_AW = 32;
  localparam int unsigned SB_DW = 32;
  localparam int unsigned SB_EVT_N = 7;

  typedef struct packed {
    logic [SB_AW-1:0] addr;
    logic [SB_DW-1:0] data;
  } sb_entry_t;
endpackage

// File: rtl/sbuf_fifo.sv
// Ring of pending stores; DEPTH must be a power of two.
module sbuf_fifo
  import sbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                push,
  input  sb_entry_t                           push_ent,
  input  logic                                pop,
  output sb_entry_t                           slot_o [DEPTH],
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] head_o,
  output logic [$clog2(DEPTH+1)-1:0]          count_o,
  output logic                                full_o,
  output logic                                empty_o,
  output sb_entry_t                           head_ent_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  sb_entry_t         slot_q [DEPTH];
  logic [PTR_W-1:0]  head_q, head_d;
  logic [PTR_W-1:0]  tail_q, tail_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // storage: enable per slot, no reset on data
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (tail_q == PTR_W'(g))) begin
        slot_q[g] <= push_ent;
      end
    end
    assign slot_o[g] = slot_q[g];
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop) begin
      head_d = head_q + PTR_W'(1);
    end
    if (push) begin
      tail_d = tail_q + PTR_W'(1);
    end
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o     = head_q;
  assign count_o    = cnt_q;
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign head_ent_o = slot_q[head_q];

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full_o);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty_o);

  // R1
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count_o == $past(count_o) + CNT_W'(1)));
endmodule

// File: rtl/sbuf_fwd.sv
// Youngest-match search over the pending ring.
module sbuf_fwd
  import sbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  sb_entry_t                           slot_i [DEPTH],
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] head_i,
  input  logic [$clog2(DEPTH+1)-1:0]          count_i,
  input  logic [SB_AW-1:0]                    ld_addr,
  output logic                                hit_o,
  output logic [SB_DW-1:0]                    hit_data_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < count_i) &&
          (slot_i[head_i + PTR_W'(i)].addr == ld_addr)) begin
        hit_o      = 1'b1;
        hit_data_o = slot_i[head_i + PTR_W'(i)].data;
      end
    end
  end
endmodule

// File: rtl/sbuf_fence.sv
// Serializing-event handshake: hold the core until the ring is empty.
module sbuf_fence
  import sbuf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SB_EVT_N-1:0] evt_i,
  input  logic                empty_i,
  output logic                busy_o,
  output logic                ack_o
);
  logic evt_any;

  assign evt_any = |evt_i;
  assign busy_o  = evt_any && !empty_i;
  assign ack_o   = evt_any && empty_i;

  // R8
  ack_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (empty_i && !busy_o));

  // R7
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$rose(busy_o)) |-> $past(evt_any));
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
  import sbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [SB_AW-1:0]    st_addr,
  input  logic [SB_DW-1:0]    st_data,
  output logic                st_ready,
  input  logic [SB_AW-1:0]    ld_addr,
  output logic [SB_DW-1:0]    ld_data,
  output logic                ld_fwd,
  input  logic [SB_DW-1:0]    mem_rdata,
  output logic                mem_req,
  output logic [SB_AW-1:0]    mem_addr,
  output logic [SB_DW-1:0]    mem_wdata,
  input  logic                mem_gnt,
  input  logic [SB_EVT_N-1:0] sync_evt,
  output logic                drain_busy,
  output logic                drain_ack
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  sb_entry_t        slot_w [DEPTH];
  sb_entry_t        head_ent;
  sb_entry_t        new_ent;
  logic [PTR_W-1:0] head_w;
  logic [CNT_W-1:0] count_w;
  logic             full_w;
  logic             empty_w;
  logic             push_w;
  logic             pop_w;
  logic             hit_w;
  logic [SB_DW-1:0] hit_data_w;

  assign new_ent.addr = st_addr;
  assign new_ent.data = st_data;

  assign st_ready = !full_w && !drain_busy && !drain_ack;
  assign push_w   = st_valid && st_ready;
  assign mem_req  = !empty_w;
  assign pop_w    = mem_req && mem_gnt;

  assign mem_addr  = head_ent.addr;
  assign mem_wdata = head_ent.data;

  sbuf_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push_w),
    .push_ent   (new_ent),
    .pop        (pop_w),
    .slot_o     (slot_w),
    .head_o     (head_w),
    .count_o    (count_w),
    .full_o     (full_w),
    .empty_o    (empty_w),
    .head_ent_o (head_ent)
  );

  sbuf_fwd #(.DEPTH(DEPTH)) fwd_i (
    .slot_i     (slot_w),
    .head_i     (head_w),
    .count_i    (count_w),
    .ld_addr    (ld_addr),
    .hit_o      (hit_w),
    .hit_data_o (hit_data_w)
  );

  sbuf_fence fence_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (sync_evt),
    .empty_i (empty_w),
    .busy_o  (drain_busy),
    .ack_o   (drain_ack)
  );

  assign ld_fwd  = hit_w;
  assign ld_data = hit_w ? hit_data_w : mem_rdata;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R7
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> !st_ready);

  // R2
  fwd_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd |-> mem_req);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (!drain_busy && !ld_fwd));
endmodule

// File: tb/sbuf_top_tb_top.sv
`timescale 1ns/100ps
module sbuf_top_tb_top;
  localparam int unsigned DEPTH = 4;

  logic        clk;
  logic        rst_n;
  logic        st_valid;
  logic [31:0] st_addr;
  logic [31:0] st_data;
  logic        st_ready;
  logic [31:0] ld_addr;
  logic [31:0] ld_data;
  logic        ld_fwd;
  logic [31:0] mem_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_gnt;
  logic [6:0]  sync_evt;
  logic        drain_busy;
  logic        drain_ack;

  int total = 0;
  int bad   = 0;
  logic [31:0] mem [16];
  logic [31:0] ref_mem [16];
  logic [31:0] qa [$];
  logic [31:0] qd [$];
  logic        seen_ack;
  logic        seen_busy;

  sbuf_top #(.DEPTH(DEPTH)) dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // shared memory: written only by the block's bus port
  always @(posedge clk) begin
    if (mem_req && mem_gnt) mem[mem_addr[5:2]] <= mem_wdata;
  end
  assign mem_rdata = mem[ld_addr[5:2]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wa(input int i);
    return {26'd0, 4'(i), 2'b00};
  endfunction

  task automatic step(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                      input logic g, input logic [31:0] la, input logic [6:0] ev);
    logic        e_ready;
    logic        e_hit;
    logic [31:0] e_ld;
    logic        do_push;
    logic        do_pop;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    mem_gnt = g; ld_addr = la; sync_evt = ev;
    #1;
    e_ready = (qa.size() < DEPTH) && (ev == '0);
    chk(st_ready == e_ready, (qa.size() >= DEPTH) ? "R6" : "R1", 32'(st_ready), 32'(e_ready));
    chk(drain_busy == ((ev != '0) && (qa.size() != 0)), "R7", 32'(drain_busy),
        32'((ev != '0) && (qa.size() != 0)));
    chk(drain_ack == ((ev != '0) && (qa.size() == 0)), "R8", 32'(drain_ack),
        32'((ev != '0) && (qa.size() == 0)));
    chk(mem_req == (qa.size() != 0), "R5", 32'(mem_req), 32'(qa.size() != 0));
    if (qa.size() != 0) begin
      chk(mem_addr == qa[0], "R5", mem_addr, qa[0]);
      chk(mem_wdata == qd[0], "R5", mem_wdata, qd[0]);
    end
    e_hit = 1'b0;
    e_ld  = ref_mem[la[5:2]];
    foreach (qa[k]) begin
      if (qa[k] == la) begin e_hit = 1'b1; e_ld = qd[k]; end
    end
    chk(ld_fwd == e_hit, e_hit ? "R2" : "R3", 32'(ld_fwd), 32'(e_hit));
    chk(ld_data == e_ld, e_hit ? "R2" : "R3", ld_data, e_ld);
    // second reader: memory itself must hold only drained values
    chk(mem[la[5:2]] == ref_mem[la[5:2]], "R4", mem[la[5:2]], ref_mem[la[5:2]]);
    seen_ack  = drain_ack;
    seen_busy = drain_busy;
    do_push = sv && e_ready;
    do_pop  = g && (qa.size() != 0);
    @(posedge clk);
    if (do_pop) begin
      ref_mem[qa[0][5:2]] = qd[0];
      void'(qa.pop_front());
      void'(qd.pop_front());
    end
    if (do_push) begin
      qa.push_back(sa);
      qd.push_back(sd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [6:0]  cur_ev;
    int          busy_n;
    for (int i = 0; i < 16; i++) begin
      mem[i]     = 32'h5a00_0000 + 32'(i);
      ref_mem[i] = 32'h5a00_0000 + 32'(i);
    end
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0;
    mem_gnt = 1'b0; ld_addr = '0; sync_evt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(st_ready == 1'b1, "R9", 32'(st_ready), 32'd1);
    chk(mem_req == 1'b0, "R9", 32'(mem_req), 32'd0);
    chk(drain_busy == 1'b0, "R9", 32'(drain_busy), 32'd0);
    chk(ld_fwd == 1'b0, "R9", 32'(ld_fwd), 32'd0);
    rst_n = 1'b1;

    // R6 fill past capacity with the bus withheld; repeated addresses
    for (int i = 0; i < DEPTH + 2; i++)
      step(1'b1, wa(i % 3), 32'hc0de_0000 + 32'(i), 1'b0, wa(i % 3), '0);
    // R2/R3 scan every word with a full ring
    for (int i = 0; i < 16; i++) step(1'b0, '0, '0, 1'b0, wa(i), '0);
    // R5 slow drain, scanning loads meanwhile
    for (int i = 0; i < 4 * DEPTH; i++)
      step(1'b0, '0, '0, (i % 2) == 1, wa(i % 4), '0);

    // R7 each serializing line over a non-empty ring
    for (int e = 0; e < 7; e++) begin
      for (int i = 0; i < 3; i++)
        step(1'b1, wa(e + i), 32'hbeef_0000 + 32'(e * 8 + i), 1'b0, wa(e), '0);
      busy_n = 0;
      seen_ack = 1'b0;
      for (int i = 0; i < 2; i++) begin
        step(1'b1, wa(9), 32'hdead_0000, 1'b0, wa(e + 2), 7'(1 << e));
        if (seen_busy) busy_n++;
      end
      for (int i = 0; i < 20 && !seen_ack; i++) begin
        step(1'b1, wa(9), 32'hdead_0001, 1'b1, wa(e + 1), 7'(1 << e));
        if (seen_busy) busy_n++;
      end
      // R7 busy for the two withheld cycles plus one per granted entry
      chk(busy_n == 5, "R7", 32'(busy_n), 32'd5);
      // R8 acknowledged once empty
      chk(seen_ack == 1'b1, "R8", 32'(seen_ack), 32'd1);
      step(1'b0, '0, '0, 1'b0, wa(e), '0);
    end

    // mixed pseudo-random phase
    lf = 32'h1357_9bdf;
    cur_ev = '0;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (cur_ev == '0 && lf[15:12] == 4'd0) cur_ev = 7'(1 << (int'(lf[18:16]) % 7));
      step(lf[0] | lf[1], wa(int'(lf[5:2])), lf ^ 32'(n), lf[8] | lf[9],
           wa(int'(lf[23:20])), cur_ev);
      if (seen_ack) cur_ev = '0;
    end
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, '0, '0, 1'b1, wa(i), '0);
    // R4 memory matches every drained value at the end
    for (int i = 0; i < 16; i++) chk(mem[i] == ref_mem[i], "R4", mem[i], ref_mem[i]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule